// File: doc/BRIEF.md
# Phase-Frequency Comparator with Lock Indicator

This block compares the rising edges of two divided clocks inside a fast system clock domain. One clock comes from the reference divider and the other from the oscillator feedback divider. Both arrive unsynchronised. Each is resampled through a synchronizer, and its rising edges are turned into one-cycle events. A small pulse engine then decides which side is ahead.

The block drives three kinds of error output at the same time:

- **Active-low pair.** One active-low error line per clock. The line of the side whose edge came first goes low and stays low until the other edge arrives. Both lines then stay low together for a short fixed tail.
- **Tri-state pump.** A single-ended charge-pump control, given as a drive level plus an output enable. It sinks while the feedback side leads, sources while the reference side leads, and floats otherwise.
- **Lock indicator.** It stays high while the two clocks agree and drops whenever exactly one error line is low.

The loop filter, the oscillator and the analogue pump stage lie outside this block.

Top module: `pfd_lock`

## Requirements
- R1: When the feedback edge is seen first, `vco_err_n` is low from the sample at which that edge is seen until MIN_W samples after the reference edge is seen. Over that span, `ref_err_n` is low only during those final MIN_W samples.
- R2: When the reference edge is seen first, the behaviour is the mirror image of R1: `ref_err_n` is low for the whole span and `vco_err_n` is low only during the final MIN_W samples.
- R3: When both edges are seen in the same system-clock cycle, both error outputs are low together for exactly MIN_W cycles (2 by default) and stay high otherwise.
- R4: While only the feedback edge is waiting for its partner, `pump_oe` is 1 and `pump_drive` is 0 (sink).
- R5: While only the reference edge is waiting for its partner, `pump_oe` is 1 and `pump_drive` is 1 (source).
- R6: In every other situation `pump_oe` is 0 (high impedance). This covers idle, the MIN_W tail and coincident edges.
- R7: `lock_ok` is 0 exactly when one error output is low and the other is high. It stays 1 when both are high and when both are low together.
- R8: Further rising edges on the leading clock, seen before the lagging edge arrives, neither lengthen nor shorten the error pulse. They also do not start a second pulse.
- R9: An input rising edge that is set up before system-clock edge t is seen at edge t+2. From there the error output changes just after edge t+2, with SYNC_STAGES = 2.
- R10: Synchronous active-low reset returns the block to idle. Both error outputs go high, `pump_oe` goes 0, `lock_ok` goes 1, and any pending edge is forgotten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample both divided clocks |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_div_in | input | 1 | Divided reference clock, asynchronous |
| vco_div_in | input | 1 | Divided feedback clock, asynchronous |
| ref_err_n | output | 1 | Active-low error line for the reference side |
| vco_err_n | output | 1 | Active-low error line for the feedback side |
| pump_drive | output | 1 | Pump level while enabled: 1 source, 0 sink |
| pump_oe | output | 1 | Pump output enable; 0 means high impedance |
| lock_ok | output | 1 | High while locked, low while one side is pending |

## Verification
The bench keeps the default build: two synchronizer stages and a 2-cycle tail. With these values the latency from input to output is a fixed two cycles. Every output can therefore be predicted per cycle from the two edge times alone.

That makes it practical to sweep every pairing of edge offsets from 0 to 8 cycles on each side. The sweep covers coincidence, every lead and lag distance up to eight cycles, and the exact first and last low cycle of each pulse. Separate runs add extra leading edges during the wait, and a reset while a pulse is in flight.

// File: rtl/phase_cmp_pkg.sv
// Shared definitions for the phase comparator.
// Assumes: channel vectors are indexed by the constants below.
package phase_cmp_pkg;

    localparam int CH_VCO = 0;
    localparam int CH_REF = 1;
    localparam int N_CH   = 2;

    typedef logic [N_CH-1:0] chan_vec_t;

    typedef enum logic [1:0] {
        PUMP_FLOAT  = 2'd0,
        PUMP_SINK   = 2'd1,
        PUMP_SOURCE = 2'd2
    } pump_mode_e;

endpackage

// File: rtl/pfd_edge_sense.sv
// Resamples one asynchronous divided clock through SYNC_STAGES flops.
// Raises a one-cycle "rise" event when the synchronised level goes 0 -> 1.
// Assumes: input high and low phases each last at least one system-clock cycle.
module pfd_edge_sense #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Shift the raw level through the synchronizer and remember the last synced level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], sig_in};
            last_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/pfd_pulse_core.sv
// Tracks which clock's edge is waiting for its partner.
// Once both edges have been seen, it holds both error lines low for MIN_W cycles.
// Assumes: rise events are single-cycle pulses from pfd_edge_sense.
module pfd_pulse_core
    import phase_cmp_pkg::*;
#(
    parameter int MIN_W = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  chan_vec_t rise,
    output chan_vec_t pend,
    output logic      tail_on,
    output logic      vco_err_n,
    output logic      ref_err_n
);

    localparam int CW = $clog2(MIN_W + 1);

    chan_vec_t       pend_q;
    chan_vec_t       seen;
    logic            both_seen;
    logic [CW-1:0]   tail_q;

    // Merge new edges with edges still waiting.
    always_comb begin
        seen      = pend_q | rise;
        both_seen = &seen;
    end

    // Hold pending edges; on a completed pair, clear them and load the tail timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            tail_q <= '0;
        end else if (both_seen) begin
            pend_q <= '0;
            tail_q <= CW'(MIN_W);
        end else begin
            pend_q <= seen;
            if (tail_q != '0) begin
                tail_q <= tail_q - 1'b1;
            end
        end
    end

    assign tail_on   = (tail_q != '0);
    assign pend      = pend_q;
    assign vco_err_n = ~(pend_q[CH_VCO] | tail_on);
    assign ref_err_n = ~(pend_q[CH_REF] | tail_on);

endmodule

// File: rtl/pfd_pump_enc.sv
// Encodes the pending state as a tri-state pump control.
// Sinks while only feedback leads, sources while only reference leads, floats otherwise.
// Assumes: at most one pending flag is set at a time.
module pfd_pump_enc
    import phase_cmp_pkg::*;
(
    input  chan_vec_t pend,
    input  logic      tail_on,
    output logic      pump_drive,
    output logic      pump_oe
);

    pump_mode_e mode;

    // Pick the pump mode from which side is waiting.
    always_comb begin
        if (tail_on) begin
            mode = PUMP_FLOAT;
        end else if (pend[CH_VCO] && !pend[CH_REF]) begin
            mode = PUMP_SINK;
        end else if (pend[CH_REF] && !pend[CH_VCO]) begin
            mode = PUMP_SOURCE;
        end else begin
            mode = PUMP_FLOAT;
        end
    end

    // Map the mode onto a level and an enable.
    always_comb begin
        case (mode)
            PUMP_SINK:   begin pump_drive = 1'b0; pump_oe = 1'b1; end
            PUMP_SOURCE: begin pump_drive = 1'b1; pump_oe = 1'b1; end
            default:     begin pump_drive = 1'b0; pump_oe = 1'b0; end
        endcase
    end

endmodule

// File: rtl/pfd_lock_ind.sv
// Lock indicator: low only while the two error lines disagree.
// Assumes: a coincident pulse on both lines means the loop is in lock.
module pfd_lock_ind (
    input  logic vco_err_n,
    input  logic ref_err_n,
    output logic lock_ok
);

    // Flag disagreement between the two active-low error lines.
    always_comb begin
        lock_ok = ~(vco_err_n ^ ref_err_n);
    end

endmodule

// File: rtl/pfd_lock.sv
// Top of the phase-frequency comparator.
// Contains two edge detectors, the pulse engine, the pump encoder and the lock indicator.
// Assumes: both divided clocks are much slower than clk.
module pfd_lock
    import phase_cmp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_W       = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_div_in,
    input  logic vco_div_in,
    output logic ref_err_n,
    output logic vco_err_n,
    output logic pump_drive,
    output logic pump_oe,
    output logic lock_ok
);

    chan_vec_t raw_in;
    chan_vec_t rise;
    chan_vec_t pend;
    logic      tail_on;

    assign raw_in[CH_VCO] = vco_div_in;
    assign raw_in[CH_REF] = ref_div_in;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_edge
        pfd_edge_sense #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (raw_in[ch]),
            .rise   (rise[ch])
        );
    end

    pfd_pulse_core #(.MIN_W(MIN_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise      (rise),
        .pend      (pend),
        .tail_on   (tail_on),
        .vco_err_n (vco_err_n),
        .ref_err_n (ref_err_n)
    );

    pfd_pump_enc u_pump (
        .pend       (pend),
        .tail_on    (tail_on),
        .pump_drive (pump_drive),
        .pump_oe    (pump_oe)
    );

    pfd_lock_ind u_lock (
        .vco_err_n (vco_err_n),
        .ref_err_n (ref_err_n),
        .lock_ok   (lock_ok)
    );

endmodule

// File: rtl/pfd_lock_chk.sv
// Property checker attached to pfd_lock.
// Relates the error lines, the pump and the lock output.
module pfd_lock_chk
    import phase_cmp_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      ref_err_n,
    input logic      vco_err_n,
    input logic      pump_drive,
    input logic      pump_oe,
    input logic      lock_ok,
    input chan_vec_t pend
);

    // R4/R6: an enabled pump means exactly one error line is low.
    p_pump_one_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pump_oe |-> (ref_err_n != vco_err_n));

    // R5: pump direction follows the side that is low.
    p_pump_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pump_oe |-> (pump_drive == !ref_err_n));

    // R7: lock drops exactly while the pump is driving.
    p_lock_vs_pump_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ok == !pump_oe);

    // R3: a low pulse on the feedback line lasts at least two cycles.
    p_vco_min_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vco_err_n) |=> !vco_err_n);

    // R3: a low pulse on the reference line lasts at least two cycles.
    p_ref_min_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_err_n) |=> !ref_err_n);

    // R8: never both sides waiting at once.
    p_single_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pend) <= 1);

endmodule

bind pfd_lock pfd_lock_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_err_n  (ref_err_n),
    .vco_err_n  (vco_err_n),
    .pump_drive (pump_drive),
    .pump_oe    (pump_oe),
    .lock_ok    (lock_ok),
    .pend       (pend)
);

// File: tb/sim_pfd_lock.sv
// Sweeping bench for pfd_lock with default parameters.
module sim_pfd_lock;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic vco_in = 1'b0;
    logic ref_err_n, vco_err_n, pump_drive, pump_oe, lock_ok;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    // Count posedges so expected times are arithmetic.
    always @(posedge clk) cyc <= cyc + 1;

    pfd_lock u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_div_in (ref_in),
        .vco_div_in (vco_in),
        .ref_err_n  (ref_err_n),
        .vco_err_n  (vco_err_n),
        .pump_drive (pump_drive),
        .pump_oe    (pump_oe),
        .lock_ok    (lock_ok)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: actual=%b expected=%b", req, what, cyc, act, exp_v);
        end
    endtask

    function automatic logic pulse_at(input int c, input int t);
        return (c >= t) && (c < t + 3);
    endfunction

    task automatic check_idle(input string req);
        check(req, "vco_err_n", vco_err_n, 1'b1);
        check(req, "ref_err_n", ref_err_n, 1'b1);
        check(req, "pump_oe",   pump_oe,   1'b0);
        check(req, "lock_ok",   lock_ok,   1'b1);
    endtask

    // One trial: rising edges at tv and tr, plus optional extra leading edges.
    task automatic trial(input int dv, input int dr, input int xv, input int xr, input string tag);
        int base, tv, tr, m;
        base = cyc;
        tv = base + 10 + dv;
        tr = base + 10 + dr;
        m  = (tv > tr) ? tv : tr;
        for (int k = 0; k < 36; k++) begin
            @(negedge clk);
            begin
                int s = cyc;
                logic vlow, rlow, leadv, leadr;
                string tv_tag, tr_tag, p_tag;
                vlow  = (s >= tv + 2) && (s <= m + 3);
                rlow  = (s >= tr + 2) && (s <= m + 3);
                leadv = (tv < tr) && (s >= tv + 2) && (s <= tr + 1);
                leadr = (tr < tv) && (s >= tr + 2) && (s <= tv + 1);
                tv_tag = (s == tv + 1 || s == tv + 2) ? "R9" : tag;
                tr_tag = (s == tr + 1 || s == tr + 2) ? "R9" : tag;
                p_tag  = leadv ? "R4" : (leadr ? "R5" : "R6");
                check(tv_tag, "vco_err_n", vco_err_n, !vlow);
                check(tr_tag, "ref_err_n", ref_err_n, !rlow);
                check(p_tag, "pump_oe", pump_oe, leadv | leadr);
                if (leadv) check("R4", "pump_drive", pump_drive, 1'b0);
                if (leadr) check("R5", "pump_drive", pump_drive, 1'b1);
                check("R7", "lock_ok", lock_ok, !(leadv | leadr));
            end
            vco_in = pulse_at(cyc + 1, tv) | ((xv > 0) && pulse_at(cyc + 1, tv + xv));
            ref_in = pulse_at(cyc + 1, tr) | ((xr > 0) && pulse_at(cyc + 1, tr + xr));
        end
        vco_in = 1'b0;
        ref_in = 1'b0;
    endtask

    initial begin
        // R10: reset state.
        repeat (3) @(negedge clk);
        check_idle("R10");
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_idle("R10");

        // R1/R2/R3/R4..R7/R9: exhaustive offset sweep.
        for (int dv = 0; dv <= 8; dv++) begin
            for (int dr = 0; dr <= 8; dr++) begin
                trial(dv, dr, 0, 0, (dv < dr) ? "R1" : ((dv > dr) ? "R2" : "R3"));
            end
        end

        // R8: extra edges on the leading side.
        trial(0, 14, 5, 0, "R8");
        trial(14, 0, 0, 5, "R8");
        trial(0, 14, 5, 0, "R8");

        // R10: reset while a pulse is in flight.
        @(negedge clk);
        vco_in = 1'b1;
        repeat (5) @(negedge clk);
        check("R10", "vco_err_n before reset", vco_err_n, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle("R10");
        vco_in = 1'b0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_idle("R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog cycle %0d: actual=running expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule